// File: doc/BRIEF.md
# Redundant Flash Converter Digital Back End

This block is the digital half of a flash converter whose front end is an unordered pool of redundant comparators. Two comparator arrays each present one output bit per comparator on every conversion strobe. A per-array enable mask picks which comparators count. In normal operation the block counts the enabled comparators that fired and registers that count as the output code. The comparators do not have to form an ordered ladder, because only the count matters.

For calibration, one array at a time is switched into a counting mode. The code path is bypassed for that array, and every comparator drives its own hit counter, masked or not. A known input distribution, such as a triangle sweep, is applied over a programmed number of strobes. The hit count of each comparator then estimates the input's cumulative distribution at that comparator's threshold. Software reads the counters back one per cycle to choose the mask.

In single-ended operation the two arrays alternate: while one calibrates, the other supplies the codes. In pseudo-differential operation a calibration run halts conversion. In that mode the difference of the two array counts passes through a first-order high-pass filter that removes slowly varying shared content.

Top module: `fadc_backend`

## Requirements
- R1: While reset is held, and on the first edge after it, `code_out`, `code_vld`, `diff_out`, `cal_busy`, `cal_done` and `rd_data` are zero, and all masks and counters are zero.
- R2: On the edge at which `conv_vld` is high and conversion is permitted, `code_out` takes the number of comparators of the converting array whose bit is 1 and whose active mask bit is 1. `code_vld` is high for the cycle that follows. A comparator whose mask bit is 0 adds nothing. `code_out` holds between conversions.
- R3: A mask write (`mask_wr` high, `mask_sel` 0 for array A and 1 for array B) goes to a staging register. The staged mask becomes active at the next edge with `conv_vld` high and governs the conversions after that edge, not the one taken at that edge.
- R4: A `cal_start` accepted while idle clears all counters of array `cal_arr` (0 = A, 1 = B) and latches `cal_len`. During the run, each strobe adds one to counter i of that array when comparator i is 1, whatever the mask says.
- R5: A 511-strobe run on a comparator that is always 1 leaves its counter at exactly 511, the full scale of the 9-bit counter.
- R6: Once `cal_len` strobes have been counted, `cal_busy` falls and `cal_done` rises on the same edge, and later strobes leave the counters unchanged. A start with `cal_len` = 0 raises `cal_done` at once and counts nothing. The next accepted start clears `cal_done`.
- R7: `rd_data` shows counter `rd_addr` of array `rd_arr` one cycle after the address is presented. Address 127 reads 0.
- R8: With `diff_mode` = 0, conversions come from array B while array A is calibrating, and from array A at all other times.
- R9: With `diff_mode` = 1, no conversion happens while a calibration run is busy: `code_vld` stays 0, and `code_out`, `diff_out` and the filter state hold.
- R10: With `diff_mode` = 1, each conversion forms d = countA − countB and t = floor(s/16), where s is the filter state (zero after reset). It sets `diff_out` = d − t and updates s to s + d − t.
- R11: A `cal_start` that arrives while a run is busy is ignored. The running array, its length and its counters are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_vld | input | 1 | Conversion strobe: comparator bits are valid this cycle |
| cmp_a | input | 127 | Comparator outputs of array A |
| cmp_b | input | 127 | Comparator outputs of array B |
| diff_mode | input | 1 | 0 single-ended, 1 pseudo-differential |
| mask_wr | input | 1 | Write the staging mask |
| mask_sel | input | 1 | Mask target array, 0 = A, 1 = B |
| mask_wdata | input | 127 | Mask value, 1 = comparator enabled |
| cal_start | input | 1 | Start a calibration run |
| cal_arr | input | 1 | Array to calibrate, 0 = A, 1 = B |
| cal_len | input | 9 | Number of strobes in the run |
| rd_arr | input | 1 | Array whose counter is read |
| rd_addr | input | 7 | Counter index to read |
| rd_data | output | 9 | Counter value, one cycle after address |
| cal_busy | output | 1 | Calibration run in progress |
| cal_done | output | 1 | Last run complete |
| code_out | output | 7 | Registered single-ended code |
| code_vld | output | 1 | `code_out` updated on the last edge |
| diff_out | output | 9 | Signed filtered differential result |

## Verification
Codes, `code_vld` and `diff_out` are due one edge after the strobe that carries the comparator bits. A counter read is due one edge after its address. `cal_busy` and `cal_done` change on the edge of the final counted strobe, and a mask write needs one strobe edge before it governs a conversion. The bench drives inputs on the falling edge and updates its behavioural model on the rising edge from the values that were present before it. It compares every output to the model on the next falling edge. Each cycle's expectation therefore already contains exactly one register stage.

// File: rtl/fadc_pkg.sv
// Shared sizes and types of the flash converter back end.
// Assumes two comparator arrays of equal size.
package fadc_pkg;
    localparam int unsigned FADC_NCMP     = 127;
    localparam int unsigned FADC_CNT_W    = 9;
    localparam int unsigned FADC_LEN_W    = 9;
    localparam int unsigned FADC_CM_SHIFT = 4;
    localparam int unsigned FADC_ACC_W    = 14;

    typedef enum logic {
        ARR_A = 1'b0,
        ARR_B = 1'b1
    } fadc_arr_e;
endpackage

// File: rtl/fadc_popcount.sv
// Masked population count: number of bits set in both 'bits' and 'en'.
// Purely combinational; the caller registers the result.
// Assumes W is wide enough to hold N.
module fadc_popcount #(
    parameter int unsigned N = 127,
    parameter int unsigned W = 7
) (
    input  logic [N-1:0] bits,
    input  logic [N-1:0] en,
    output logic [W-1:0] count
);
    // Accumulate enabled high comparators; order is irrelevant.
    always_comb begin
        count = '0;
        for (int i = 0; i < int'(N); i++) begin
            count = count + {{(W-1){1'b0}}, bits[i] & en[i]};
        end
    end
endmodule

// File: rtl/fadc_cal_bank.sv
// Bank of per-comparator hit counters for one array, with a combinational
// read mux. Assumes runs never exceed 2**CW-1 increments after a clear,
// so counters need no saturation.
module fadc_cal_bank #(
    parameter int unsigned N  = 127,
    parameter int unsigned CW = 9,
    parameter int unsigned AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [N-1:0]  hits,
    input  logic [AW-1:0] rd_addr,
    output logic [CW-1:0] rd_val
);
    logic [CW-1:0] cnt_q [N];

    for (genvar g = 0; g < int'(N); g++) begin : g_cnt
        // One counter: clear on reset or run start, count a hit per strobe.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                cnt_q[g] <= '0;
            end else if (inc && hits[g]) begin
                cnt_q[g] <= cnt_q[g] + 1'b1;
            end
        end

        // R5: a counted hit never arrives at full scale (no wrap)
        a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (inc && hits[g] && !clr) |-> (cnt_q[g] != {CW{1'b1}}));
    end

    // Select the addressed counter; out-of-range addresses read zero.
    always_comb begin
        rd_val = '0;
        if (int'(rd_addr) < int'(N)) begin
            rd_val = cnt_q[rd_addr];
        end
    end
endmodule

// File: rtl/fadc_cm_filter.sv
// First-order high-pass on the difference of two array counts. The state
// tracks 2**SHIFT times the running mean of the difference; the output is
// the difference minus that mean. Assumes ACC_W holds 2**(IN_W+SHIFT+1).
module fadc_cm_filter #(
    parameter int unsigned IN_W  = 7,
    parameter int unsigned ACC_W = 14,
    parameter int unsigned OUT_W = 9,
    parameter int unsigned SHIFT = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic [IN_W-1:0]         sum_p,
    input  logic [IN_W-1:0]         sum_n,
    output logic signed [OUT_W-1:0] y
);
    localparam int BOUND = (1 << IN_W) << SHIFT;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] d_w;
    logic signed [ACC_W-1:0] trk_w;
    logic signed [ACC_W-1:0] acc_nx;
    logic signed [ACC_W-1:0] y_nx;

    // Next state and output from the current difference.
    always_comb begin
        d_w    = $signed(ACC_W'(sum_p)) - $signed(ACC_W'(sum_n));
        trk_w  = acc_q >>> SHIFT;
        acc_nx = acc_q + d_w - trk_w;
        y_nx   = d_w - trk_w;
    end

    // Advance the filter only on an accepted differential conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            y     <= '0;
        end else if (upd) begin
            acc_q <= acc_nx;
            y     <= y_nx[OUT_W-1:0];
        end
    end

    // R10: the leaky state stays inside its stable range
    a_r10_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(acc_q) <= BOUND) && (int'(acc_q) >= -BOUND));
endmodule

// File: rtl/fadc_backend.sv
// Top of the flash converter back end: staged enable masks, code
// formation from the converting array, calibration run control with
// per-array counter banks, a registered read port and the differential
// filter. Assumes one sample per conv_vld strobe and cal_len <= 2**LEN_W-1.
module fadc_backend
    import fadc_pkg::*;
#(
    parameter int unsigned NCMP     = FADC_NCMP,
    parameter int unsigned CNT_W    = FADC_CNT_W,
    parameter int unsigned LEN_W    = FADC_LEN_W,
    parameter int unsigned CM_SHIFT = FADC_CM_SHIFT,
    parameter int unsigned ACC_W    = FADC_ACC_W,
    localparam int unsigned CODE_W  = $clog2(NCMP + 1),
    localparam int unsigned ADDR_W  = $clog2(NCMP + 1),
    localparam int unsigned DIFF_W  = CODE_W + 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     conv_vld,
    input  logic [NCMP-1:0]          cmp_a,
    input  logic [NCMP-1:0]          cmp_b,
    input  logic                     diff_mode,
    input  logic                     mask_wr,
    input  logic                     mask_sel,
    input  logic [NCMP-1:0]          mask_wdata,
    input  logic                     cal_start,
    input  logic                     cal_arr,
    input  logic [LEN_W-1:0]         cal_len,
    input  logic                     rd_arr,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [CNT_W-1:0]         rd_data,
    output logic                     cal_busy,
    output logic                     cal_done,
    output logic [CODE_W-1:0]        code_out,
    output logic                     code_vld,
    output logic signed [DIFF_W-1:0] diff_out
);
    localparam int unsigned NARR = 2;

    logic [NCMP-1:0]   cmp_v    [NARR];
    logic [NCMP-1:0]   stage_q  [NARR];
    logic [NCMP-1:0]   active_q [NARR];
    logic [CODE_W-1:0] pop_w    [NARR];
    logic [CNT_W-1:0]  rd_val_w [NARR];
    logic [NARR-1:0]   bank_clr;
    logic [NARR-1:0]   bank_inc;

    logic              busy_q;
    logic              done_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  smp_q;
    fadc_arr_e         arr_q;
    logic              accept_w;
    fadc_arr_e         conv_sel_w;
    logic              start_ok_w;

    assign cmp_v[0] = cmp_a;
    assign cmp_v[1] = cmp_b;

    assign accept_w   = conv_vld && !(diff_mode && busy_q);
    assign conv_sel_w = (busy_q && arr_q == ARR_A) ? ARR_B : ARR_A;
    assign start_ok_w = cal_start && !busy_q;

    for (genvar k = 0; k < int'(NARR); k++) begin : g_arr
        // Staged mask capture and activation at a conversion strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[k]  <= '0;
                active_q[k] <= '0;
            end else begin
                if (conv_vld) begin
                    active_q[k] <= stage_q[k];
                end
                if (mask_wr && (int'(mask_sel) == k)) begin
                    stage_q[k] <= mask_wdata;
                end
            end
        end

        fadc_popcount #(
            .N (NCMP),
            .W (CODE_W)
        ) u_pop (
            .bits  (cmp_v[k]),
            .en    (active_q[k]),
            .count (pop_w[k])
        );

        assign bank_clr[k] = start_ok_w && (int'(cal_arr) == k);
        assign bank_inc[k] = busy_q && conv_vld && (int'(arr_q) == k);

        fadc_cal_bank #(
            .N  (NCMP),
            .CW (CNT_W),
            .AW (ADDR_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (bank_clr[k]),
            .inc     (bank_inc[k]),
            .hits    (cmp_v[k]),
            .rd_addr (rd_addr),
            .rd_val  (rd_val_w[k])
        );
    end

    // Register the single-ended code of the converting array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_out <= '0;
            code_vld <= 1'b0;
        end else begin
            code_vld <= accept_w;
            if (accept_w) begin
                code_out <= pop_w[conv_sel_w];
            end
        end
    end

    // Calibration run control: start, count strobes, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            len_q  <= '0;
            smp_q  <= '0;
            arr_q  <= ARR_A;
        end else if (busy_q) begin
            if (conv_vld) begin
                smp_q <= smp_q + 1'b1;
                if ((smp_q + 1'b1) == len_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end else if (cal_start) begin
            len_q  <= cal_len;
            arr_q  <= fadc_arr_e'(cal_arr);
            smp_q  <= '0;
            busy_q <= (cal_len != '0);
            done_q <= (cal_len == '0);
        end
    end

    // Registered counter readout from the selected array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else begin
            rd_data <= rd_arr ? rd_val_w[1] : rd_val_w[0];
        end
    end

    fadc_cm_filter #(
        .IN_W  (CODE_W),
        .ACC_W (ACC_W),
        .OUT_W (DIFF_W),
        .SHIFT (CM_SHIFT)
    ) u_cm (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (accept_w && diff_mode),
        .sum_p (pop_w[0]),
        .sum_n (pop_w[1]),
        .y     (diff_out)
    );

    assign cal_busy = busy_q;
    assign cal_done = done_q;

    // R6: busy and done are never both set
    a_r6_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);

    // R6: a busy run has counted fewer strobes than its length
    a_r6_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (smp_q < len_q));

    // R9: a strobe during a differential calibration yields no code
    a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_mode && busy_q && conv_vld) |=> !code_vld);

    // R11: a start request during a run leaves the run length alone
    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cal_start) |=> (len_q == $past(len_q)));
endmodule

// File: tb/fadc_backend_tb_top.sv
// Self-checking bench: behavioural reference model updated on each rising
// edge, compared with the outputs on each falling edge.
module fadc_backend_tb_top;
    localparam int N = 127;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             conv_vld = 1'b0;
    logic [N-1:0]     cmp_a = '0;
    logic [N-1:0]     cmp_b = '0;
    logic             diff_mode = 1'b0;
    logic             mask_wr = 1'b0;
    logic             mask_sel = 1'b0;
    logic [N-1:0]     mask_wdata = '0;
    logic             cal_start = 1'b0;
    logic             cal_arr = 1'b0;
    logic [8:0]       cal_len = '0;
    logic             rd_arr = 1'b0;
    logic [6:0]       rd_addr = '0;
    logic [8:0]       rd_data;
    logic             cal_busy;
    logic             cal_done;
    logic [6:0]       code_out;
    logic             code_vld;
    logic signed [8:0] diff_out;

    fadc_backend dut_i (
        .clk(clk), .rst_n(rst_n), .conv_vld(conv_vld), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .diff_mode(diff_mode), .mask_wr(mask_wr),
        .mask_sel(mask_sel), .mask_wdata(mask_wdata), .cal_start(cal_start),
        .cal_arr(cal_arr), .cal_len(cal_len), .rd_arr(rd_arr),
        .rd_addr(rd_addr), .rd_data(rd_data), .cal_busy(cal_busy),
        .cal_done(cal_done), .code_out(code_out), .code_vld(code_vld),
        .diff_out(diff_out)
    );

    always #10 clk = ~clk;

    int n_vec = 0;
    int n_bad = 0;
    bit started = 1'b0;
    string cur_req = "R1";

    int thr_a [N];
    int thr_b [N];

    // reference model state
    int          m_cnt [2][N];
    logic [N-1:0] m_stage [2];
    logic [N-1:0] m_active [2];
    int m_busy, m_done, m_len, m_smp, m_arr, m_s;
    int e_code, e_vld, e_diff, e_rd;
    int pa, pb, dd, tt, csel;

    function automatic logic [N-1:0] quant(input int v, input bit arr_b);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = arr_b ? (v > thr_b[i]) : (v > thr_a[i]);
        return r;
    endfunction

    function automatic int tri_wave(input int n);
        int p;
        p = n % 512;
        return (p < 256) ? p : 511 - p;
    endfunction

    // reference model: one rising edge of the block, from pre-edge inputs
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            for (int a = 0; a < 2; a++) begin
                for (int i = 0; i < N; i++) m_cnt[a][i] = 0;
                m_stage[a] = '0;
                m_active[a] = '0;
            end
            m_busy = 0; m_done = 0; m_len = 0; m_smp = 0; m_arr = 0; m_s = 0;
            e_code = 0; e_vld = 0; e_diff = 0; e_rd = 0;
        end else begin
            e_rd = (rd_addr < 7'd127) ? m_cnt[rd_arr][rd_addr] : 0;
            pa = $countones(cmp_a & m_active[0]);
            pb = $countones(cmp_b & m_active[1]);
            if (conv_vld && !(diff_mode && m_busy != 0)) begin
                csel = (m_busy != 0 && m_arr == 0) ? 1 : 0;
                e_code = (csel == 1) ? pb : pa;
                e_vld = 1;
                if (diff_mode) begin
                    dd = pa - pb;
                    tt = m_s >>> 4;
                    e_diff = dd - tt;
                    m_s = m_s + dd - tt;
                end
            end else begin
                e_vld = 0;
            end
            if (m_busy != 0) begin
                if (conv_vld) begin
                    for (int i = 0; i < N; i++)
                        m_cnt[m_arr][i] += (m_arr == 0) ? int'(cmp_a[i]) : int'(cmp_b[i]);
                    m_smp++;
                    if (m_smp == m_len) begin
                        m_busy = 0;
                        m_done = 1;
                    end
                end
            end else if (cal_start) begin
                for (int i = 0; i < N; i++) m_cnt[cal_arr][i] = 0;
                m_len = int'(cal_len);
                m_arr = int'(cal_arr);
                m_smp = 0;
                m_busy = (m_len != 0) ? 1 : 0;
                m_done = (m_len == 0) ? 1 : 0;
            end
            if (conv_vld) begin
                m_active[0] = m_stage[0];
                m_active[1] = m_stage[1];
            end
            if (mask_wr) m_stage[mask_sel] = mask_wdata;
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare every output against the model away from the rising edge
    always @(negedge clk) begin
        if (started) begin
            n_vec++;
            chk("code_vld", int'(code_vld), e_vld);
            chk("code_out", int'(code_out), e_code);
            chk("diff_out", int'(diff_out), e_diff);
            chk("cal_busy", int'(cal_busy), m_busy);
            chk("cal_done", int'(cal_done), m_done);
            chk("rd_data", int'(rd_data), e_rd);
        end
    end

    int t_n = 0;

    // one cycle of stimulus; pulses clear unless the caller re-raises them
    task automatic step(input int va, input int vb, input bit vld);
        @(negedge clk);
        mask_wr = 1'b0;
        cal_start = 1'b0;
        conv_vld = vld;
        cmp_a = quant(va, 1'b0);
        cmp_b = quant(vb, 1'b1);
    endtask

    task automatic ramp_step(input bit vld);
        step(tri_wave(t_n), tri_wave(t_n + 97), vld);
        t_n++;
    endtask

    task automatic write_mask(input bit sel, input logic [N-1:0] m);
        ramp_step(1'b0);
        mask_wr = 1'b1;
        mask_sel = sel;
        mask_wdata = m;
    endtask

    task automatic start_cal(input bit arr, input int len);
        ramp_step(1'b1);
        cal_start = 1'b1;
        cal_arr = arr;
        cal_len = 9'(len);
    endtask

    function automatic logic [N-1:0] rnd_mask();
        logic [127:0] w;
        w = {$urandom, $urandom, $urandom, $urandom};
        return w[N-1:0];
    endfunction

    task automatic read_all(input bit arr);
        for (int a = 0; a < 128; a++) begin
            ramp_step(1'b0);
            rd_arr = arr;
            rd_addr = 7'(a);
        end
        ramp_step(1'b0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            thr_a[i] = int'($urandom_range(0, 254));
            thr_b[i] = int'($urandom_range(0, 254));
        end
        thr_a[0] = -1;   // always-firing comparator for the full-scale run

        cur_req = "R1";
        for (int i = 0; i < 4; i++) ramp_step(1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: all-ones mask on A only governs strobes after activation
        cur_req = "R3";
        write_mask(1'b0, '1);
        for (int i = 0; i < 3; i++) ramp_step(1'b1);

        // R2: full-mask codes along the ramp, with idle gaps
        cur_req = "R2";
        for (int i = 0; i < 300; i++) ramp_step(($urandom_range(0, 3) != 0));

        // R3: random mask written mid-stream
        cur_req = "R3";
        write_mask(1'b0, rnd_mask());
        for (int i = 0; i < 20; i++) ramp_step(1'b1);

        // R2: mask of zeros makes every comparator contribute nothing
        cur_req = "R2";
        write_mask(1'b0, '0);
        for (int i = 0; i < 20; i++) ramp_step(1'b1);

        // R8: calibrate A for 511 strobes; codes come from B meanwhile
        cur_req = "R8";
        write_mask(1'b1, rnd_mask());
        write_mask(1'b0, rnd_mask());
        ramp_step(1'b1);
        start_cal(1'b0, 511);
        for (int i = 0; i < 530; i++) ramp_step(1'b1);

        // R5: counter 0 of A saw a comparator that always fired
        cur_req = "R5";
        ramp_step(1'b0);
        rd_arr = 1'b0;
        rd_addr = 7'd0;
        ramp_step(1'b0);
        ramp_step(1'b0);

        // R4 and R7: all counters of A (mask ignored), address 127 reads zero
        cur_req = "R7";
        read_all(1'b0);

        // R11: a start on A during a run on B is ignored
        cur_req = "R11";
        start_cal(1'b1, 40);
        for (int i = 0; i < 10; i++) ramp_step(1'b1);
        start_cal(1'b0, 5);
        for (int i = 0; i < 60; i++) ramp_step(($urandom_range(0, 2) != 0));
        for (int i = 0; i < 30; i++) ramp_step(1'b1);

        // R4: B counters hold the run, A counters untouched
        cur_req = "R4";
        read_all(1'b1);
        read_all(1'b0);

        // R6: zero-length run finishes at once; later strobes count nothing
        cur_req = "R6";
        start_cal(1'b1, 0);
        for (int i = 0; i < 10; i++) ramp_step(1'b1);
        read_all(1'b1);
        start_cal(1'b1, 3);
        for (int i = 0; i < 8; i++) ramp_step(1'b1);

        // R10: pseudo-differential codes through the filter
        cur_req = "R10";
        diff_mode = 1'b1;
        write_mask(1'b0, rnd_mask());
        write_mask(1'b1, rnd_mask());
        for (int i = 0; i < 300; i++) begin
            step(tri_wave(t_n), 255 - tri_wave(t_n) + 20 * ((i / 40) % 3),
                 ($urandom_range(0, 4) != 0));
            t_n++;
        end

        // R9: differential calibration halts conversion
        cur_req = "R9";
        start_cal(1'b0, 30);
        for (int i = 0; i < 40; i++) ramp_step(1'b1);
        cur_req = "R10";
        for (int i = 0; i < 60; i++) ramp_step(1'b1);

        finish_run();
    end
endmodule